// File: doc/BRIEF.md
# Start-Sequence Packet Receiver

This block turns a single-wire optical serial stream into whole packets for the host. The line carries 8N1 frames: one start bit, eight data bits sent least significant bit first, and one stop bit. `CLK_DIV` clock cycles make up each bit period, so the default of 8 gives 6.25 Mbps from a 50 MHz clock, and 12 gives about 4.17 Mbps. The receiver synchronizes the line and confirms each start bit at mid-bit. It samples every data bit at the centre of its period and checks the stop bit. Each byte it accepts goes to a sliding header search.

Once the 32-bit start sequence has been seen, the next four bytes form the packet tag and the following `PAYLOAD_BYTES` bytes go into an internal buffer. When the buffer is full, the payload is offered on a valid/ready byte stream with the tag alongside. The stream obeys these back-pressure rules:
- `out_valid_o` stays high until a byte is taken.
- A byte is transferred on a rising clock edge where both `out_valid_o` and `out_ready_i` are high.
- While a byte waits to be taken, `out_data_o`, `out_last_o` and `out_tag_o` do not change.

The line cannot be paused. Bytes that arrive while the buffer is draining are therefore discarded, and a sticky overflow flag records the loss.

A byte with a bad stop bit is counted as a framing error and abandons the packet in progress. The block also reports the clock count from the first header byte to the last payload byte, from which link throughput can be computed.

Top module: `optrx_packet_rx`

## Requirements
- R1: After reset, `out_valid_o` is low, and `frame_err_count_o`, `overflow_o` and `pkt_cycles_o` are all zero.
- R2: A low pulse shorter than half a bit period is not taken as a start bit. Data bits are sampled at bit centres and assembled least significant bit first.
- R3: The start sequence is `START_SEQ`, sent most significant byte first. It is matched across the last four received bytes at any byte position, including after a partial match, and a packet begins only once all four bytes have been seen.
- R4: The four bytes after the start sequence form `out_tag_o`, with the first received byte in bits 7:0 and the last in bits 31:24. The tag is valid whenever `out_valid_o` is high.
- R5: No payload byte is offered until all `PAYLOAD_BYTES` bytes have arrived. Bytes are then offered in arrival order, and `out_last_o` is high only with the final byte.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` and `out_tag_o` hold their values.
- R7: A frame whose stop bit samples low increments `frame_err_count_o` by one. It delivers no byte, abandons any packet in progress and returns the receiver to header hunting.
- R8: A byte that arrives while the buffer is draining is dropped and sets `overflow_o`, which stays set until reset. The drained payload is unaffected, and hunting resumes once the last byte has been taken.
- R9: After the final byte is taken, `out_valid_o` drops. No header bytes received before or during the drain can combine with later bytes to start a new packet.
- R10: `pkt_cycles_o` is loaded when a packet completes. It holds the clock count from the strobe of the first header byte to the strobe of the last payload byte, which is `(7+PAYLOAD_BYTES)*10*CLK_DIV` for back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Serial line from the optical receiver, idle high |
| out_valid_o | output | 1 | Payload byte available |
| out_ready_i | input | 1 | Host accepts the offered byte |
| out_data_o | output | 8 | Payload byte |
| out_last_o | output | 1 | Offered byte is the final payload byte |
| out_tag_o | output | 32 | Tag of the packet being drained |
| frame_err_count_o | output | ERR_W | Wrapping count of frames with a bad stop bit |
| overflow_o | output | 1 | Sticky: a byte was dropped during a drain |
| pkt_cycles_o | output | CYC_W | Clocks from first header byte to last payload byte |

## Verification
Received bytes are strobed close to the middle of their stop bit, at most `CLK_DIV/2+2` cycles into it. The bench drives each frame for exactly `10*CLK_DIV` cycles on falling edges. It therefore samples packet completion, the error count and the overflow flag a few cycles after the stop bit of the relevant byte has ended, when all of them are due. Stream outputs are sampled on falling edges: the ready chosen at one falling edge takes effect at the next rising edge, so the following falling edge already shows the next byte or a stalled, unchanged one. The bench derives the throughput count from the number of frames between the first header byte and the last payload byte, and checks for the absence of packets and overflow at the ports after each stimulus.

// File: rtl/optrx_pkg.sv
package optrx_pkg;

  typedef enum logic [1:0] {
    SER_IDLE,
    SER_START,
    SER_DATA,
    SER_STOP
  } ser_state_e;

  typedef enum logic [1:0] {
    PK_HUNT,
    PK_TAG,
    PK_PAY,
    PK_DRAIN
  } pkt_state_e;

endpackage

// File: rtl/optrx_serial_rx.sv
module optrx_serial_rx
  import optrx_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_o,
  output logic       frame_err_o
);

  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic [1:0]  sync_q;
  logic        line_s;
  ser_state_e  st;
  logic [CW-1:0] cnt;
  logic [2:0]  bit_idx;
  logic [7:0]  shift_q;

  assign line_s = sync_q[1];
  assign byte_o = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], line_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= SER_IDLE;
      cnt          <= '0;
      bit_idx      <= '0;
      shift_q      <= '0;
      byte_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
      unique case (st)
        SER_IDLE: begin
          cnt <= '0;
          if (!line_s) st <= SER_START;
        end
        SER_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt     <= '0;
            bit_idx <= '0;
            st      <= line_s ? SER_IDLE : SER_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SER_DATA: begin
          if (cnt == CW'(CLK_DIV - 1)) begin
            cnt     <= '0;
            shift_q <= {line_s, shift_q[7:1]};
            if (bit_idx == 3'd7) st <= SER_STOP;
            bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SER_STOP: begin
          if (cnt == CW'(CLK_DIV - 1)) begin
            cnt          <= '0;
            byte_valid_o <= line_s;
            frame_err_o  <= !line_s;
            st           <= SER_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SER_IDLE;
      endcase
    end
  end

  // R7: a frame ends either in a byte or in an error, never both
  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid_o && frame_err_o));

  // R2: one frame yields at most one single-cycle byte strobe
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);

endmodule

// File: rtl/optrx_header_hunt.sv
module optrx_header_hunt #(
  parameter logic [31:0] START_SEQ = 32'hD53AC659,
  parameter int          TW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  input  logic [TW-1:0] stamp_i,
  output logic          match_o,
  output logic [TW-1:0] first_stamp_o
);

  localparam int SLOTS = 3;

  logic [7:0]    hist_b [SLOTS];
  logic [TW-1:0] hist_t [SLOTS];
  logic [1:0]    fill;

  assign match_o       = byte_valid_i && !clear_i && (fill == 2'd3) &&
                         ({hist_b[2], hist_b[1], hist_b[0], byte_i} == START_SEQ);
  assign first_stamp_o = hist_t[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (clear_i) begin
      fill <= '0;
    end else if (byte_valid_i && fill != 2'd3) begin
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_b[0] <= '0;
      hist_t[0] <= '0;
    end else if (byte_valid_i && !clear_i) begin
      hist_b[0] <= byte_i;
      hist_t[0] <= stamp_i;
    end
  end

  for (genvar g = 1; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_b[g] <= '0;
        hist_t[g] <= '0;
      end else if (byte_valid_i && !clear_i) begin
        hist_b[g] <= hist_b[g-1];
        hist_t[g] <= hist_t[g-1];
      end
    end
  end

  // R3: after a clear, no match is possible until three more bytes have shifted in
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !match_o);

endmodule

// File: rtl/optrx_payload_buf.sv
module optrx_payload_buf #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/optrx_packet_rx.sv
module optrx_packet_rx
  import optrx_pkg::*;
#(
  parameter int          CLK_DIV       = 8,
  parameter int          PAYLOAD_BYTES = 1024,
  parameter logic [31:0] START_SEQ     = 32'hD53AC659,
  parameter int          ERR_W         = 16,
  parameter int          CYC_W         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  output logic [31:0]      out_tag_o,
  output logic [ERR_W-1:0] frame_err_count_o,
  output logic             overflow_o,
  output logic [CYC_W-1:0] pkt_cycles_o
);

  localparam int AW = (PAYLOAD_BYTES > 1) ? $clog2(PAYLOAD_BYTES) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(PAYLOAD_BYTES - 1);

  logic             byte_valid;
  logic [7:0]       rx_byte;
  logic             frame_err;
  logic             hdr_match;
  logic             hunt_clear;
  logic [CYC_W-1:0] first_stamp;
  logic [CYC_W-1:0] now_q;
  logic [CYC_W-1:0] start_stamp;
  pkt_state_e       state;
  logic [1:0]       tag_cnt;
  logic [31:0]      tag_q;
  logic [AW-1:0]    wr_idx;
  logic [AW-1:0]    rd_idx;
  logic             buf_wr;
  logic             take;

  optrx_serial_rx #(.CLK_DIV(CLK_DIV)) u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (rx_line_i),
    .byte_valid_o (byte_valid),
    .byte_o       (rx_byte),
    .frame_err_o  (frame_err)
  );

  assign hunt_clear = (state != PK_HUNT) || frame_err;

  optrx_header_hunt #(.START_SEQ(START_SEQ), .TW(CYC_W)) u_hunt (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (hunt_clear),
    .byte_valid_i  (byte_valid),
    .byte_i        (rx_byte),
    .stamp_i       (now_q),
    .match_o       (hdr_match),
    .first_stamp_o (first_stamp)
  );

  assign buf_wr = (state == PK_PAY) && byte_valid;

  optrx_payload_buf #(.DEPTH(PAYLOAD_BYTES), .AW(AW)) u_buf (
    .clk       (clk),
    .wr_en_i   (buf_wr),
    .wr_addr_i (wr_idx),
    .wr_data_i (rx_byte),
    .rd_addr_i (rd_idx),
    .rd_data_o (out_data_o)
  );

  assign out_valid_o = (state == PK_DRAIN);
  assign out_last_o  = out_valid_o && (rd_idx == LAST_IDX);
  assign out_tag_o   = tag_q;
  assign take        = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_err_count_o <= '0;
    end else if (frame_err) begin
      frame_err_count_o <= frame_err_count_o + ERR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= PK_HUNT;
      tag_cnt      <= '0;
      tag_q        <= '0;
      wr_idx       <= '0;
      rd_idx       <= '0;
      start_stamp  <= '0;
      pkt_cycles_o <= '0;
      overflow_o   <= 1'b0;
    end else begin
      unique case (state)
        PK_HUNT: begin
          if (hdr_match) begin
            state       <= PK_TAG;
            tag_cnt     <= '0;
            start_stamp <= first_stamp;
          end
        end
        PK_TAG: begin
          if (frame_err) begin
            state <= PK_HUNT;
          end else if (byte_valid) begin
            tag_q   <= {rx_byte, tag_q[31:8]};
            tag_cnt <= tag_cnt + 1'b1;
            if (tag_cnt == 2'd3) begin
              state  <= PK_PAY;
              wr_idx <= '0;
            end
          end
        end
        PK_PAY: begin
          if (frame_err) begin
            state <= PK_HUNT;
          end else if (byte_valid) begin
            if (wr_idx == LAST_IDX) begin
              state        <= PK_DRAIN;
              rd_idx       <= '0;
              pkt_cycles_o <= now_q - start_stamp;
            end else begin
              wr_idx <= wr_idx + 1'b1;
            end
          end
        end
        PK_DRAIN: begin
          if (byte_valid) overflow_o <= 1'b1;
          if (take) begin
            if (rd_idx == LAST_IDX) state <= PK_HUNT;
            else                    rd_idx <= rd_idx + 1'b1;
          end
        end
        default: state <= PK_HUNT;
      endcase
    end
  end

  // R6: a stalled byte and its tag hold until taken
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_tag_o)));

  // R9: taking the final byte ends the offer at once
  a_r9_end_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o);

  // R7: each framing error adds exactly one to the count
  a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (frame_err_count_o == $past(frame_err_count_o) + ERR_W'(1)));

  // R7: the count moves only on a framing error
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_err |=> $stable(frame_err_count_o));

  // R8: overflow is raised only by a byte arriving during a drain
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(out_valid_o && byte_valid));

  // R5: an offer begins only on the strobe of a payload byte
  a_r5_offer_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(state == PK_PAY && byte_valid));

  // R3: tag collection starts only on a received byte
  a_r3_hunt_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PK_TAG && $past(state) == PK_HUNT) |-> $past(byte_valid));

endmodule

// File: tb/optrx_packet_rx_test.sv
module optrx_packet_rx_test;

  localparam int          CD   = 8;
  localparam int          N    = 16;
  localparam logic [31:0] SEQ  = 32'hD53AC659;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic [31:0] out_tag;
  logic [15:0] err_cnt;
  logic        ovf;
  logic [31:0] cycles;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0] pay [N];

  always #10 clk = ~clk;

  optrx_packet_rx #(.CLK_DIV(CD), .PAYLOAD_BYTES(N), .START_SEQ(SEQ)) uut (
    .clk(clk), .rst_n(rst_n), .rx_line_i(line),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last), .out_tag_o(out_tag), .frame_err_count_o(err_cnt),
    .overflow_o(ovf), .pkt_cycles_o(cycles)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    line = 1'b0;
    repeat (CD) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      line = b[i];
      repeat (CD) @(negedge clk);
    end
    line = stop_ok;
    repeat (CD) @(negedge clk);
    line = 1'b1;
  endtask

  task automatic send_head_tag(input logic [31:0] tag);
    for (int i = 3; i >= 0; i--) send_byte(SEQ[i*8 +: 8], 1'b1);
    for (int i = 0; i < 4; i++)  send_byte(tag[i*8 +: 8], 1'b1);
  endtask

  task automatic send_pay(input int count);
    for (int i = 0; i < count; i++) send_byte(pay[i], 1'b1);
  endtask

  task automatic fill_pay(input int mul, input int add);
    for (int i = 0; i < N; i++) pay[i] = 8'((i * mul + add) & 255);
  endtask

  task automatic collect(input int stall_mod, input logic [31:0] exp_tag, input string req);
    int got = 0;
    int guard = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    while (got < N && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (out_valid) begin
        if (stalled) chk(out_data == held, "R6", "stalled byte held", out_data, held);
        if (stall_mod == 0 || (guard % stall_mod) != 0) begin
          out_ready = 1'b1;
          chk(out_data == pay[got], req, "payload byte", out_data, pay[got]);
          chk(out_last == (got == N - 1), "R5", "last flag", out_last, (got == N - 1));
          if (got == 0) chk(out_tag == exp_tag, "R4", "tag", out_tag, exp_tag);
          got++;
          stalled = 0;
        end else begin
          out_ready = 1'b0;
          stalled = 1;
          held = out_data;
        end
      end else begin
        out_ready = 1'b0;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(got == N, req, "bytes delivered", got, N);
    chk(!out_valid, "R9", "valid drops after last", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete, got %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!out_valid, "R1", "valid after reset", out_valid, 0);
    chk(err_cnt == 0, "R1", "error count after reset", err_cnt, 0);
    chk(!ovf, "R1", "overflow after reset", ovf, 0);
    chk(cycles == 0, "R1", "cycle count after reset", cycles, 0);

    // R3/R5/R10: junk, then a packet sent back to back
    fill_pay(7, 3);
    send_byte(8'hD5, 1'b1);
    send_byte(8'h00, 1'b1);
    send_byte(8'hFF, 1'b1);
    send_head_tag(32'h12345678);
    send_pay(N - 1);
    chk(!out_valid, "R5", "no offer before payload complete", out_valid, 0);
    send_byte(pay[N-1], 1'b1);
    repeat (3) @(negedge clk);
    chk(out_valid, "R5", "offer after payload complete", out_valid, 1);
    chk(cycles == (7 + N) * 10 * CD, "R10", "header-to-end cycles", cycles, (7 + N) * 10 * CD);
    collect(3, 32'h12345678, "R5");

    // R2: short glitch ignored; R3: sliding match after partial header
    line = 1'b0;
    repeat (2) @(negedge clk);
    line = 1'b1;
    repeat (2 * CD) @(negedge clk);
    chk(err_cnt == 0, "R2", "glitch makes no error", err_cnt, 0);
    fill_pay(13, 40);
    send_byte(SEQ[31:24], 1'b1);
    send_byte(SEQ[23:16], 1'b1);
    send_head_tag(32'hA1B2C3D4);
    send_pay(N);
    repeat (3) @(negedge clk);
    chk(out_valid, "R3", "packet found after partial header", out_valid, 1);
    chk(err_cnt == 0, "R2", "no error from clean frames", err_cnt, 0);
    collect(0, 32'hA1B2C3D4, "R3");

    // R7: bad stop bit aborts a packet in progress
    fill_pay(5, 11);
    send_head_tag(32'h0BADF00D);
    send_pay(5);
    send_byte(8'h3C, 1'b0);
    repeat (12 * 10 * CD) @(negedge clk);
    chk(err_cnt == 1, "R7", "error counted", err_cnt, 1);
    send_pay(N);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R7", "aborted packet not completed", out_valid, 0);

    // R7/R8: receiver hunts again; overflow during a drain
    fill_pay(3, 90);
    send_head_tag(32'hCAFE0001);
    send_pay(N);
    repeat (3) @(negedge clk);
    chk(out_valid, "R7", "new packet after error", out_valid, 1);
    chk(!ovf, "R8", "no overflow yet", ovf, 0);
    send_byte(8'h55, 1'b1);
    send_byte(8'hAA, 1'b1);
    repeat (3) @(negedge clk);
    chk(ovf, "R8", "overflow set by byte during drain", ovf, 1);
    chk(out_valid, "R8", "drain continues", out_valid, 1);
    collect(2, 32'hCAFE0001, "R8");
    chk(ovf, "R8", "overflow sticky", ovf, 1);

    // R9: header fragment at end of payload plus rest after drain is not a packet
    fill_pay(9, 1);
    pay[N-3] = SEQ[31:24];
    pay[N-2] = SEQ[23:16];
    pay[N-1] = SEQ[15:8];
    send_head_tag(32'h00000042);
    send_pay(N);
    repeat (3) @(negedge clk);
    chk(out_valid, "R9", "packet with header fragment", out_valid, 1);
    collect(0, 32'h00000042, "R9");
    send_byte(SEQ[7:0], 1'b1);
    for (int i = 0; i < 4; i++) send_byte(8'h11, 1'b1);
    send_pay(N);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R9", "no packet from split header", out_valid, 0);

    // R8: hunting resumed after drains
    fill_pay(11, 200);
    send_head_tag(32'h5EED0003);
    send_pay(N);
    repeat (3) @(negedge clk);
    chk(out_valid, "R8", "hunting resumed", out_valid, 1);
    collect(4, 32'h5EED0003, "R8");
    chk(err_cnt == 1, "R7", "error count unchanged by clean traffic", err_cnt, 1);

    finish_run();
  end

endmodule